// File: doc/BRIEF.md
# Dual Microsecond Limit Timer

This block holds two independent counter/limit channels behind a small synchronous register port. A one-cycle tick strobe, generated elsewhere once per microsecond, advances every enabled channel. Each channel counts upward towards its programmed limit. When the next count would reach that limit, the counter goes back to 1, not 0, so the channel repeats every limit minus one ticks. To get a period of n microseconds, software programs a limit of n+1.

Every wrap sets a sticky flag. The flag drives the channel's interrupt request line. Channel 0 feeds the lower-priority line and channel 1 feeds the higher-priority line. Software acknowledges a channel by reading that channel's limit register.

Both register kinds use the same 32-bit word layout. The sticky flag is at the top. A 21-bit microsecond field sits directly below it. The ten lowest bits are always zero. Writing a limit restarts that channel.

Top module: `dual_limit_timer`

## Requirements
- R1: While reset is asserted and after it is released, every counter reads 1 (word 0x0000_0400), every limit reads 0, every flag and `irq_o` bit is 0, and `rdata_o` is 0.
- R2: With a limit field L of 2 or more, each cycle with `tick_i` high advances the counter by one. When the advanced value would equal L, the counter reloads to 1 instead. For L=4 the counter reads 1, 2, 3, 1, 2, 3. For L=2 every tick reloads to 1.
- R3: A reload at the limit sets the channel's flag (bit 31 of both its registers) and its interrupt. Channel 0 drives `irq_o[0]` and channel 1 drives `irq_o[1]`. The flag and interrupt stay set through further ticks.
- R4: A read of a channel's limit register returns the flag value held before that read in bit 31, and clears the flag and the interrupt on the same edge. If a wrap happens on that same edge, the flag ends up set.
- R5: A write to a limit register stores bits 30:10 of `wdata_i` and ignores bits 31 and 9:0. On the same edge it reloads that channel's counter to 1 and clears its flag and interrupt.
- R6: A limit field of 0 or 1 stops the channel. The counter stays at 1 and the flag never sets.
- R7: Word addresses are 0 for the channel 0 counter, 1 for the channel 0 limit, 2 for the channel 1 counter and 3 for the channel 1 limit. Read data has the flag in bit 31, the value in bits 30:10 and zeros in bits 9:0. Read data appears on `rdata_o` on the edge that accepts the read and holds until the next read.
- R8: Writes to a counter register have no effect. Reading a counter register does not clear the flag.
- R9: The channels are independent. Writes, reads and wraps on one channel leave the other channel's registers and interrupt unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle microsecond advance strobe |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 2 | Word address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 2 | Per-channel interrupt: bit 0 is the lower priority, bit 1 the higher |

## Verification
The assertions assume that `tick_i`, `req_i`, `we_i` and `addr_i` are valid on every clock edge after reset, and that only addresses of channels that exist are used. The stimulus meets this by driving all inputs on the falling edge, one register access at a time. Limits are only changed through the limit register, which restarts the counter, so the counter always stays below an active limit. The one deliberate collision is a limit read on the same edge as a wrap, which exercises the set-over-clear rule.

// File: rtl/dlt_pkg.sv
package dlt_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned USEC_W   = 21;
  localparam int unsigned USEC_LSB = 10;
  localparam int unsigned FLAG_BIT = DATA_W - 1;

  typedef logic [USEC_W-1:0] usec_t;
  typedef logic [DATA_W-1:0] word_t;

  function automatic word_t pack_word(input logic flag, input usec_t val);
    word_t w;
    w = '0;
    w[FLAG_BIT] = flag;
    w[USEC_LSB +: USEC_W] = val;
    return w;
  endfunction
endpackage

// File: rtl/dlt_channel.sv
module dlt_channel
  import dlt_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  tick_i,
  input  logic  lim_we_i,
  input  usec_t lim_wval_i,
  input  logic  lim_rd_i,
  output usec_t cnt_o,
  output usec_t lim_o,
  output logic  flag_o
);
  localparam usec_t ONE = usec_t'(1);

  usec_t cnt_q, lim_q, cnt_inc;
  logic  flag_q, active, hit;

  assign active  = lim_q > ONE;
  assign cnt_inc = cnt_q + ONE;
  // >= keeps the channel safe even if count ever passes the limit
  assign hit     = tick_i && active && (cnt_inc >= lim_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= ONE;
      lim_q  <= '0;
      flag_q <= 1'b0;
    end else if (lim_we_i) begin
      lim_q  <= lim_wval_i;
      cnt_q  <= ONE;
      flag_q <= 1'b0;
    end else begin
      if (tick_i && active) cnt_q <= hit ? ONE : cnt_inc;
      if (hit)           flag_q <= 1'b1;  // set beats read-clear
      else if (lim_rd_i) flag_q <= 1'b0;
    end
  end

  assign cnt_o  = cnt_q;
  assign lim_o  = lim_q;
  assign flag_o = flag_q;

  p_cnt_nonzero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q != '0);
  p_cnt_in_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active |-> (cnt_q < lim_q));
  p_flag_after_tick_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> ($past(tick_i) && cnt_q == ONE));
  p_rd_clears_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lim_rd_i && !tick_i) |=> !flag_q);
  p_lim_we_restart_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lim_we_i |=> (cnt_q == ONE && !flag_q));
  p_idle_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |-> (cnt_q == ONE && !flag_q));
endmodule

// File: rtl/dlt_regif.sv
module dlt_regif
  import dlt_pkg::*;
#(
  parameter int unsigned N_CH   = 2,
  parameter int unsigned ADDR_W = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_i,
  input  logic                  we_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  word_t                 wdata_i,
  input  usec_t [N_CH-1:0]      cnt_i,
  input  usec_t [N_CH-1:0]      lim_i,
  input  logic  [N_CH-1:0]      flag_i,
  output logic  [N_CH-1:0]      lim_we_o,
  output logic  [N_CH-1:0]      lim_rd_o,
  output usec_t                 lim_wval_o,
  output word_t                 rdata_o
);
  localparam int unsigned CH_W = ADDR_W - 1;

  logic [CH_W-1:0] ch_idx;
  logic            is_lim;
  word_t           rd_word, rdata_q;
  logic            unused_wbits;

  assign ch_idx = addr_i[ADDR_W-1:1];
  assign is_lim = addr_i[0];

  assign lim_wval_o   = wdata_i[USEC_LSB +: USEC_W];
  assign unused_wbits = ^{wdata_i[FLAG_BIT], wdata_i[USEC_LSB-1:0]};

  for (genvar c = 0; c < N_CH; c++) begin : g_strobe
    assign lim_we_o[c] = req_i &&  we_i && is_lim && (ch_idx == CH_W'(c));
    assign lim_rd_o[c] = req_i && !we_i && is_lim && (ch_idx == CH_W'(c));
  end

  always_comb begin
    if (is_lim) rd_word = pack_word(flag_i[ch_idx], lim_i[ch_idx]);
    else        rd_word = pack_word(flag_i[ch_idx], cnt_i[ch_idx]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             rdata_q <= '0;
    else if (req_i && !we_i) rdata_q <= rd_word;
  end

  assign rdata_o = rdata_q;

  p_one_strobe_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({lim_we_o, lim_rd_o}));
  p_rdata_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> $stable(rdata_o));
  p_pad_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[USEC_LSB-1:0] == '0);
endmodule

// File: rtl/dual_limit_timer.sv
module dual_limit_timer
  import dlt_pkg::*;
#(
  parameter int unsigned N_CH   = 2,
  parameter int unsigned ADDR_W = $clog2(2 * N_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic [N_CH-1:0]   irq_o
);
  usec_t [N_CH-1:0] cnt, lim;
  logic  [N_CH-1:0] flag, lim_we, lim_rd;
  usec_t            lim_wval;

  dlt_regif #(.N_CH(N_CH), .ADDR_W(ADDR_W)) u_regif (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .cnt_i      (cnt),
    .lim_i      (lim),
    .flag_i     (flag),
    .lim_we_o   (lim_we),
    .lim_rd_o   (lim_rd),
    .lim_wval_o (lim_wval),
    .rdata_o    (rdata_o)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    dlt_channel u_ch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .tick_i     (tick_i),
      .lim_we_i   (lim_we[c]),
      .lim_wval_i (lim_wval),
      .lim_rd_i   (lim_rd[c]),
      .cnt_o      (cnt[c]),
      .lim_o      (lim[c]),
      .flag_o     (flag[c])
    );
  end

  assign irq_o = flag;

  p_irq_clear_in_reset_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (irq_o == '0));
  p_irq_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(irq_o[0]) && !$past(req_i)) |-> irq_o[0]);
endmodule

// File: tb/dual_limit_timer_tb.sv
module dual_limit_timer_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [1:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [1:0]  irq_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;
  logic        done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  dual_limit_timer u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .req_i(req_i),
    .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .irq_o(irq_o)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read words as the design returns them
  always @(posedge clk) rd_seen <= rst_ni && req_i && !we_i;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R7: unexpected read data %h expected none", rdata_o);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(rdata_o, e, t);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    req_i = 1'b0; we_i = 1'b0; wdata_i = '0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] e, input string t, input logic tk = 1'b0);
    req_i = 1'b1; we_i = 1'b0; addr_i = a; tick_i = tk;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    req_i = 1'b0; tick_i = 1'b0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      tick_i = 1'b1;
      @(negedge clk);
      tick_i = 1'b0;
    end
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({30'd0, irq_o}, 32'd0, "R1 irq in reset");
    chk(rdata_o, 32'd0, "R1 rdata in reset");
    rst_ni = 1'b1;
    @(negedge clk);
    rd(2'd0, 32'h0000_0400, "R1 ch0 cnt");
    rd(2'd1, 32'h0000_0000, "R1 ch0 lim");
    rd(2'd2, 32'h0000_0400, "R1 ch1 cnt");
    rd(2'd3, 32'h0000_0000, "R1 ch1 lim");

    // limit 4 with junk in bit 31 and bits 9:0
    wr(2'd1, 32'h8000_13FF);
    rd(2'd1, 32'h0000_1000, "R5 ignored bits");
    rd(2'd0, 32'h0000_0400, "R5 restart");

    tick(1); rd(2'd0, 32'h0000_0800, "R2 count 2");
    tick(1); rd(2'd0, 32'h0000_0C00, "R2 count 3");
    chk({31'd0, irq_o[0]}, 32'd0, "R3 no irq before wrap");
    tick(1); rd(2'd0, 32'h8000_0400, "R2 R3 wrap to 1 with flag");
    chk({31'd0, irq_o[0]}, 32'd1, "R3 irq_o[0] set");
    chk({31'd0, irq_o[1]}, 32'd0, "R9 irq_o[1] untouched");
    rd(2'd2, 32'h0000_0400, "R6 ch1 limit 0 holds");
    rd(2'd0, 32'h8000_0400, "R8 counter read keeps flag");
    tick(2); rd(2'd0, 32'h8000_0C00, "R3 flag sticky");

    rd(2'd1, 32'h8000_1000, "R4 limit read returns flag");
    chk({31'd0, irq_o[0]}, 32'd0, "R4 irq cleared");
    rd(2'd0, 32'h0000_0C00, "R4 flag cleared");

    // read-clear and wrap on the same edge
    rd(2'd1, 32'h0000_1000, "R4 race old flag", 1'b1);
    chk({31'd0, irq_o[0]}, 32'd1, "R4 set wins");
    rd(2'd1, 32'h8000_1000, "R4 race flag kept");
    chk({31'd0, irq_o[0]}, 32'd0, "R4 clear after race");

    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, 32'h0000_0400, "R8 counter write ignored");
    rd(2'd1, 32'h0000_1000, "R8 limit unchanged");

    wr(2'd3, 32'h0000_0400);
    tick(5);
    rd(2'd2, 32'h0000_0400, "R6 limit 1 holds");
    chk({31'd0, irq_o[1]}, 32'd0, "R6 no irq");
    chk({31'd0, irq_o[0]}, 32'd1, "R9 ch0 runs alone");
    rd(2'd3, 32'h0000_0400, "R7 ch1 limit readback");

    wr(2'd3, 32'h0000_0800);
    tick(1);
    rd(2'd2, 32'h8000_0400, "R2 limit 2 wraps each tick");
    chk({31'd0, irq_o[1]}, 32'd1, "R3 irq_o[1] set");

    wr(2'd3, 32'h0000_1400);
    chk({31'd0, irq_o[1]}, 32'd0, "R5 write clears irq");
    rd(2'd2, 32'h0000_0400, "R5 write restarts");
    tick(3);
    rd(2'd2, 32'h0000_1000, "R2 period 4 count 4");
    chk({31'd0, irq_o[1]}, 32'd0, "R2 no early wrap");
    tick(1);
    rd(2'd2, 32'h8000_0400, "R2 period 4 wrap");
    chk({31'd0, irq_o[1]}, 32'd1, "R3 ch1 wrap irq");

    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, 32'h7FFF_FC00, "R7 full field");
    chk({31'd0, irq_o[0]}, 32'd0, "R5 ch0 irq cleared");
    chk({31'd0, irq_o[1]}, 32'd1, "R9 ch1 irq kept");
    rd(2'd0, 32'h0000_0400, "R5 ch0 restart");

    rst_ni = 1'b0;
    @(negedge clk);
    chk({30'd0, irq_o}, 32'd0, "R1 irq on reset");
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    rd(2'd3, 32'h0000_0000, "R1 ch1 lim after reset");
    rd(2'd2, 32'h0000_0400, "R1 ch1 cnt after reset");
    rd(2'd1, 32'h0000_0000, "R1 ch0 lim after reset");
    rd(2'd0, 32'h0000_0400, "R1 ch0 cnt after reset");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL R7: %0d reads unanswered, expected 0", exp_q.size());
    end
    done = 1'b1;
    summary();
    $finish;
  end
endmodule